// File: doc/BRIEF.md
# Interrupt Pending Capture

This block sits between raw interrupt request wires and the priority logic of an interrupt controller. For every source it holds a stored copy of the request line, an enable bit, a pending bit, an edge/level trigger selection and a free model flag. Each cycle it compares every request line with its stored copy. A rising line makes the source pending when the source is edge-triggered, or when it is level-triggered and enabled. A falling line only updates the stored copy.

Software reaches the state through a byte-wide register bus. There are separate set and clear windows for enables and for pendings, and a configuration window with two bits per source. The controller core reports acknowledge and end-of-interrupt events, each carrying a source ID. An acknowledge removes the pending bit. An end-of-interrupt re-arms a level source whose line is still high. The block drives only the enable and pending vectors; choosing among them is left to the next stage.

The lowest sixteen IDs are always enabled and always edge-triggered. The edge bit cannot be cleared for any ID below 32.

Top module: `irq_pending_capture`

## Requirements
- R1: When a request line falls, the stored level clears one cycle later and the pending bit is unchanged.
- R2: On a rising line (line high, stored level low), the source becomes pending if it is edge-triggered or if its enable after this cycle's bus write is 1. A disabled level source that rises does not become pending.
- R3: An end-of-interrupt for ID n sets n pending when n is level-triggered, enabled and its stored level is high. It has no effect on an edge source, on a level source whose stored line is low, or when the ID is not below NUM_SRC.
- R4: Writing 1 to the set-enable bit of a level-triggered source whose stored level is high also makes it pending.
- R5: An acknowledge with ID n clears pending for n in the next cycle, whatever its trigger mode.
- R6: Configuration byte at offset 0xC00+k covers IDs 4k..4k+3. For ID 4k+j, bit 2j+1 is the trigger (1 = edge, 0 = level) and bit 2j is the model flag. For IDs below 32 the trigger bit is stored as 1 whatever is written.
- R7: After reset, IDs 0..15 are enabled and edge-triggered, and every other enable, pending, level, trigger and model bit is 0. Enables of IDs 0..15 stay 1 under any clear-enable write.
- R8: The windows are set-enable at 0x100+b, clear-enable at 0x180+b, set-pending at 0x200+b and clear-pending at 0x280+b. In each, bit i of byte b addresses ID 8b+i; a 1 acts on that ID and a 0 leaves it alone.
- R9: A read of either enable window returns the enable bits of that byte, and a read of either pending window returns the pending bits. The configuration window returns the stored pairs, and an address outside all windows reads 0, with writes to it ignored.
- R10: All state updates are registered and become visible one cycle after the event. Events on different IDs in the same cycle all take effect, and on one ID a set cause wins over a clear cause in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_SRC | Raw request lines, synchronous to clk |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| ack_valid | input | 1 | Acknowledge event strobe |
| ack_id | input | ID_W | ID being acknowledged |
| eoi_valid | input | 1 | End-of-interrupt event strobe |
| eoi_id | input | ID_W | ID being completed |
| enable_vec | output | NUM_SRC | Enable bit per source |
| pending_vec | output | NUM_SRC | Pending bit per source |

## Verification
The properties assume the request lines are already synchronous to clk and change only between edges. They also assume that at most one register access and one event of each kind arrive per cycle. Several properties are guarded to cycles with no bus write or competing event on the same ID, because a set cause there would mask the effect under test. The stimulus changes lines and strobes only on falling clock edges and holds each strobe for exactly one cycle. The dedicated checks for acknowledge, fall and masked-rise behaviour are run in quiet cycles. The same-cycle collisions are driven on purpose and judged by the bench model.

// File: rtl/irqcap_pkg.sv
package irqcap_pkg;

   // Register window bases (byte addresses)
   localparam int unsigned WIN_SET_EN = 'h100;
   localparam int unsigned WIN_CLR_EN = 'h180;
   localparam int unsigned WIN_SET_PD = 'h200;
   localparam int unsigned WIN_CLR_PD = 'h280;
   localparam int unsigned WIN_CFG    = 'hC00;

   // IDs per byte in each kind of window
   localparam int unsigned IDS_PER_BIT_BYTE = 8;
   localparam int unsigned IDS_PER_CFG_BYTE = 4;

   // Per-source decoded write command
   typedef struct packed {
      logic set_en;
      logic clr_en;
      logic set_pd;
      logic clr_pd;
      logic cfg_wr;
      logic cfg_edge;
      logic cfg_model;
   } src_cmd_t;

endpackage

// File: rtl/irqcap_regdec.sv
module irqcap_regdec
   import irqcap_pkg::*;
#(
   parameter int unsigned NUM_SRC        = 64,
   parameter int unsigned ADDR_W         = 12,
   parameter int unsigned FORCE_EDGE_IDS = 32
) (
   input  logic                      bus_wr,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [7:0]                wdata,
   output src_cmd_t [NUM_SRC-1:0]    cmd
);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_dec
      localparam int unsigned BYTE_I = i / IDS_PER_BIT_BYTE;
      localparam int unsigned BIT_I  = i % IDS_PER_BIT_BYTE;
      localparam int unsigned CFG_I  = i / IDS_PER_CFG_BYTE;
      localparam int unsigned PAIR_I = i % IDS_PER_CFG_BYTE;
      localparam bit          FORCED = (i < FORCE_EDGE_IDS);

      logic bit_on;
      assign bit_on = wdata[BIT_I];

      assign cmd[i].set_en = bus_wr && (addr == ADDR_W'(WIN_SET_EN + BYTE_I)) && bit_on;
      assign cmd[i].clr_en = bus_wr && (addr == ADDR_W'(WIN_CLR_EN + BYTE_I)) && bit_on;
      assign cmd[i].set_pd = bus_wr && (addr == ADDR_W'(WIN_SET_PD + BYTE_I)) && bit_on;
      assign cmd[i].clr_pd = bus_wr && (addr == ADDR_W'(WIN_CLR_PD + BYTE_I)) && bit_on;
      assign cmd[i].cfg_wr = bus_wr && (addr == ADDR_W'(WIN_CFG + CFG_I));

      if (FORCED) begin : g_forced
         assign cmd[i].cfg_edge = 1'b1;
      end else begin : g_free
         assign cmd[i].cfg_edge = wdata[2*PAIR_I+1];
      end
      assign cmd[i].cfg_model = wdata[2*PAIR_I];
   end

endmodule

// File: rtl/irqcap_cell.sv
module irqcap_cell
   import irqcap_pkg::*;
#(
   parameter bit LOCKED     = 1'b0,
   parameter bit RESET_EDGE = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     line,
   input  src_cmd_t cmd,
   input  logic     ack_hit,
   input  logic     eoi_hit,
   output logic     en_q,
   output logic     pd_q,
   output logic     lvl_q,
   output logic     edge_q,
   output logic     model_q
);

   logic en_d, pd_d, edge_d, model_d;
   logic rise, pd_set, pd_clr;

   always_comb begin
      if (LOCKED)           en_d = 1'b1;
      else if (cmd.set_en)  en_d = 1'b1;
      else if (cmd.clr_en)  en_d = 1'b0;
      else                  en_d = en_q;

      rise   = line & ~lvl_q;
      pd_set = (rise & (edge_q | en_d))
             | (eoi_hit & ~edge_q & en_q & lvl_q)
             | (cmd.set_en & ~edge_q & lvl_q)
             | cmd.set_pd;
      pd_clr = ack_hit | cmd.clr_pd;
      pd_d   = pd_set | (pd_q & ~pd_clr);

      edge_d  = cmd.cfg_wr ? cmd.cfg_edge  : edge_q;
      model_d = cmd.cfg_wr ? cmd.cfg_model : model_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= LOCKED;
         pd_q    <= 1'b0;
         lvl_q   <= 1'b0;
         edge_q  <= RESET_EDGE;
         model_q <= 1'b0;
      end else begin
         en_q    <= en_d;
         pd_q    <= pd_d;
         lvl_q   <= line;
         edge_q  <= edge_d;
         model_q <= model_d;
      end
   end

endmodule

// File: rtl/irqcap_rdmux.sv
module irqcap_rdmux
   import irqcap_pkg::*;
#(
   parameter int unsigned NUM_SRC = 64,
   parameter int unsigned ADDR_W  = 12
) (
   input  logic [ADDR_W-1:0]  addr,
   input  logic [NUM_SRC-1:0] en_vec,
   input  logic [NUM_SRC-1:0] pd_vec,
   input  logic [NUM_SRC-1:0] edge_vec,
   input  logic [NUM_SRC-1:0] model_vec,
   output logic [7:0]         rdata
);

   localparam int unsigned NBYTE = NUM_SRC / IDS_PER_BIT_BYTE;
   localparam int unsigned NCFG  = NUM_SRC / IDS_PER_CFG_BYTE;

   always_comb begin
      rdata = '0;
      for (int b = 0; b < NBYTE; b++) begin
         if (addr == ADDR_W'(WIN_SET_EN + b) || addr == ADDR_W'(WIN_CLR_EN + b))
            rdata = en_vec[b*8 +: 8];
         if (addr == ADDR_W'(WIN_SET_PD + b) || addr == ADDR_W'(WIN_CLR_PD + b))
            rdata = pd_vec[b*8 +: 8];
      end
      for (int c = 0; c < NCFG; c++) begin
         if (addr == ADDR_W'(WIN_CFG + c)) begin
            for (int j = 0; j < 4; j++) begin
               rdata[2*j]   = model_vec[4*c + j];
               rdata[2*j+1] = edge_vec[4*c + j];
            end
         end
      end
   end

endmodule

// File: rtl/irq_pending_capture.sv
module irq_pending_capture
   import irqcap_pkg::*;
#(
   parameter int unsigned NUM_SRC        = 64,
   parameter int unsigned ADDR_W         = 12,
   parameter int unsigned ID_W           = 10,
   parameter int unsigned LOCK_IDS       = 16,
   parameter int unsigned FORCE_EDGE_IDS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               bus_valid,
   input  logic               bus_write,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [7:0]         bus_wdata,
   output logic [7:0]         bus_rdata,
   input  logic               ack_valid,
   input  logic [ID_W-1:0]    ack_id,
   input  logic               eoi_valid,
   input  logic [ID_W-1:0]    eoi_id,
   output logic [NUM_SRC-1:0] enable_vec,
   output logic [NUM_SRC-1:0] pending_vec
);

   // Elaboration-time parameter checks
   if (NUM_SRC % 32 != 0 || NUM_SRC == 0)
      $error("NUM_SRC must be a non-zero multiple of 32");
   if (NUM_SRC > 1020)
      $error("NUM_SRC too large");
   if (ADDR_W < 12)
      $error("ADDR_W must cover the configuration window");
   if ((1 << ID_W) <= NUM_SRC)
      $error("ID_W too narrow for NUM_SRC");
   if (LOCK_IDS % 8 != 0 || LOCK_IDS > FORCE_EDGE_IDS || FORCE_EDGE_IDS > NUM_SRC)
      $error("lock and forced-edge ranges are inconsistent");

   logic                 bus_wr;
   src_cmd_t [NUM_SRC-1:0] cmd;
   logic [NUM_SRC-1:0]   level_vec;
   logic [NUM_SRC-1:0]   edge_vec;
   logic [NUM_SRC-1:0]   model_vec;

   assign bus_wr = bus_valid && bus_write;

   irqcap_regdec #(
      .NUM_SRC        (NUM_SRC),
      .ADDR_W         (ADDR_W),
      .FORCE_EDGE_IDS (FORCE_EDGE_IDS)
   ) u_dec (
      .bus_wr (bus_wr),
      .addr   (bus_addr),
      .wdata  (bus_wdata),
      .cmd    (cmd)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      logic ack_hit, eoi_hit;
      assign ack_hit = ack_valid && (ack_id == ID_W'(i));
      assign eoi_hit = eoi_valid && (eoi_id == ID_W'(i));

      irqcap_cell #(
         .LOCKED     (i < LOCK_IDS),
         .RESET_EDGE (i < LOCK_IDS)
      ) u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .line    (irq_in[i]),
         .cmd     (cmd[i]),
         .ack_hit (ack_hit),
         .eoi_hit (eoi_hit),
         .en_q    (enable_vec[i]),
         .pd_q    (pending_vec[i]),
         .lvl_q   (level_vec[i]),
         .edge_q  (edge_vec[i]),
         .model_q (model_vec[i])
      );
   end

   irqcap_rdmux #(
      .NUM_SRC (NUM_SRC),
      .ADDR_W  (ADDR_W)
   ) u_rd (
      .addr      (bus_addr),
      .en_vec    (enable_vec),
      .pd_vec    (pending_vec),
      .edge_vec  (edge_vec),
      .model_vec (model_vec),
      .rdata     (bus_rdata)
   );

endmodule

// File: rtl/irqcap_chk.sv
module irqcap_chk #(
   parameter int unsigned NUM_SRC  = 64,
   parameter int unsigned ID_W     = 10,
   parameter int unsigned LOCK_IDS = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] irq_in,
   input logic               bus_valid,
   input logic               bus_write,
   input logic               ack_valid,
   input logic [ID_W-1:0]    ack_id,
   input logic               eoi_valid,
   input logic [NUM_SRC-1:0] enable_vec,
   input logic [NUM_SRC-1:0] pending_vec,
   input logic [NUM_SRC-1:0] level_vec,
   input logic [NUM_SRC-1:0] edge_vec
);

   logic quiet_bus;
   assign quiet_bus = !(bus_valid && bus_write);

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_p
      // R2: edge source latches any rise
      a_r2_edge_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_in[i] && !level_vec[i] && edge_vec[i]) |=> pending_vec[i]);

      // R2: disabled level source is not latched
      a_r2_masked_level_ignored: assert property (@(posedge clk) disable iff (!rst_n)
         (irq_in[i] && !level_vec[i] && !edge_vec[i] && !enable_vec[i]
          && quiet_bus && !eoi_valid && !pending_vec[i]) |=> !pending_vec[i]);

      // R1: falling line keeps pending
      a_r1_fall_keeps_pending: assert property (@(posedge clk) disable iff (!rst_n)
         (pending_vec[i] && !irq_in[i] && level_vec[i] && !ack_valid && quiet_bus)
         |=> pending_vec[i]);

      // R5: acknowledge clears pending
      a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_valid && ack_id == ID_W'(i) && !(irq_in[i] && !level_vec[i])
          && !eoi_valid && quiet_bus) |=> !pending_vec[i]);

      if (i < LOCK_IDS) begin : g_lock
         // R7: locked IDs stay enabled and edge-triggered
         a_r7_locked_state: assert property (@(posedge clk) disable iff (!rst_n)
            enable_vec[i] && edge_vec[i]);
      end
   end

endmodule

bind irq_pending_capture irqcap_chk #(
   .NUM_SRC  (NUM_SRC),
   .ID_W     (ID_W),
   .LOCK_IDS (LOCK_IDS)
) u_chk (.*);

// File: tb/irq_pending_capture_test.sv
module irq_pending_capture_test;

   localparam int N = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] irq_in = '0;
   logic        bus_valid = 1'b0, bus_write = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        ack_valid = 1'b0, eoi_valid = 1'b0;
   logic [9:0]  ack_id = '0, eoi_id = '0;
   logic [N-1:0] enable_vec, pending_vec;

   always #2 clk = ~clk;

   irq_pending_capture uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
      .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ack_valid(ack_valid), .ack_id(ack_id),
      .eoi_valid(eoi_valid), .eoi_id(eoi_id),
      .enable_vec(enable_vec), .pending_vec(pending_vec)
   );

   int total = 0, bad = 0, cyc = 0;
   bit done = 1'b0;

   // Reference state built from the requirements
   logic [N-1:0] m_en, m_pd, m_lvl, m_edge, m_model;

   typedef struct {
      string        tag;
      int           due;
      logic [N-1:0] en;
      logic [N-1:0] pd;
   } exp_t;
   exp_t q[$];

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Monitor: compares queued expectations one cycle after their stimulus
   initial begin
      forever begin
         @(posedge clk);
         #1;
         while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " enable"}, enable_vec, e.en);
            chk({e.tag, " pending"}, pending_vec, e.pd);
         end
      end
   end

   // Driver: called at a falling edge; updates model, drives, queues expectation
   task automatic apply(input logic [N-1:0] lines, input bit wr, input int a, input int d,
                        input bit av, input int aid, input bit ev, input int eid,
                        input string tag);
      logic [N-1:0] n_en, n_pd, n_edge, n_model;
      for (int i = 0; i < N; i++) begin
         bit s_en, c_en, s_pd, c_pd, cfg, rise, ak, eo, setc;
         s_en = wr && a == 'h100 + i/8 && d[i%8];
         c_en = wr && a == 'h180 + i/8 && d[i%8];
         s_pd = wr && a == 'h200 + i/8 && d[i%8];
         c_pd = wr && a == 'h280 + i/8 && d[i%8];
         cfg  = wr && a == 'hC00 + i/4;
         n_en[i] = (i < 16) ? 1'b1 : s_en ? 1'b1 : c_en ? 1'b0 : m_en[i];
         rise = lines[i] && !m_lvl[i];
         ak = av && aid == i;
         eo = ev && eid == i;
         setc = (rise && (m_edge[i] || n_en[i])) ||
                (eo && !m_edge[i] && m_en[i] && m_lvl[i]) ||
                (s_en && !m_edge[i] && m_lvl[i]) || s_pd;
         n_pd[i]    = setc || (m_pd[i] && !(ak || c_pd));
         n_edge[i]  = cfg ? (d[2*(i%4)+1] || i < 32) : m_edge[i];
         n_model[i] = cfg ? d[2*(i%4)] : m_model[i];
      end
      m_en = n_en; m_pd = n_pd; m_edge = n_edge; m_model = n_model; m_lvl = lines;
      irq_in    = lines;
      bus_valid = wr; bus_write = wr;
      bus_addr  = 12'(a); bus_wdata = 8'(d);
      ack_valid = av; ack_id = 10'(aid);
      eoi_valid = ev; eoi_id = 10'(eid);
      q.push_back('{tag, cyc + 1, m_en, m_pd});
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      ack_valid = 1'b0; eoi_valid = 1'b0;
   endtask

   task automatic wr(input int a, input int d, input string tag);
      apply(irq_in, 1'b1, a, d, 1'b0, 0, 1'b0, 0, tag);
   endtask
   task automatic line(input int id, input bit v, input string tag);
      logic [N-1:0] l;
      l = irq_in; l[id] = v;
      apply(l, 1'b0, 0, 0, 1'b0, 0, 1'b0, 0, tag);
   endtask
   task automatic ack(input int id, input string tag);
      apply(irq_in, 1'b0, 0, 0, 1'b1, id, 1'b0, 0, tag);
   endtask
   task automatic eoi(input int id, input string tag);
      apply(irq_in, 1'b0, 0, 0, 1'b0, 0, 1'b1, id, tag);
   endtask

   function automatic logic [7:0] rd_model(input int a);
      logic [7:0] r;
      r = '0;
      if (a >= 'h100 && a < 'h100 + N/8) r = m_en[(a-'h100)*8 +: 8];
      if (a >= 'h180 && a < 'h180 + N/8) r = m_en[(a-'h180)*8 +: 8];
      if (a >= 'h200 && a < 'h200 + N/8) r = m_pd[(a-'h200)*8 +: 8];
      if (a >= 'h280 && a < 'h280 + N/8) r = m_pd[(a-'h280)*8 +: 8];
      if (a >= 'hC00 && a < 'hC00 + N/4)
         for (int j = 0; j < 4; j++) begin
            r[2*j]   = m_model[(a-'hC00)*4 + j];
            r[2*j+1] = m_edge[(a-'hC00)*4 + j];
         end
      return r;
   endfunction

   task automatic rd(input int a, input logic [7:0] exp, input string tag);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = 12'(a);
      #1;
      chk(tag, N'(bus_rdata), N'(exp));
      chk({tag, " model"}, N'(bus_rdata), N'(rd_model(a)));
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_en = N'(16'hFFFF); m_edge = N'(16'hFFFF);
      m_pd = '0; m_lvl = '0; m_model = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R7: reset state
      chk("R7 reset enable", enable_vec, N'(16'hFFFF));
      chk("R7 reset pending", pending_vec, '0);
      rd('h100, 8'hFF, "R7 enable byte0");
      rd('h101, 8'hFF, "R7 enable byte1");
      rd('h102, 8'h00, "R7 enable byte2");
      rd('hC00, 8'hAA, "R7 cfg ids0-3 edge");
      rd('hC04, 8'h00, "R7 cfg ids16-19 level at reset");

      // R6: make ID 40 edge-triggered
      wr('hC0A, 'h02, "R6 cfg write");
      rd('hC0A, 8'h02, "R6 cfg readback");

      // R2 / R1 / R5 on an edge source while disabled
      line(40, 1'b1, "R2 edge rise");
      chk("R2 disabled edge source pends", N'(pending_vec[40]), N'(1));
      line(40, 1'b0, "R1 fall");
      chk("R1 fall keeps pending", N'(pending_vec[40]), N'(1));
      rd('h205, 8'h01, "R9 pending byte5");
      ack(40, "R5 ack edge");
      chk("R5 ack clears edge", N'(pending_vec[40]), N'(0));

      // Level source ID 41
      line(41, 1'b1, "R2 level rise disabled");
      chk("R2 disabled level not latched", N'(pending_vec[41]), N'(0));
      wr('h105, 'h02, "R4 set-enable");
      chk("R4 enable with high line pends", N'(pending_vec[41]), N'(1));
      ack(41, "R5 ack level");
      chk("R5 ack clears level", N'(pending_vec[41]), N'(0));
      eoi(41, "R3 eoi high");
      chk("R3 eoi re-pends high level", N'(pending_vec[41]), N'(1));
      ack(41, "R5 ack again");
      line(41, 1'b0, "R1 level fall");
      eoi(41, "R3 eoi low");
      chk("R3 eoi with low line no pend", N'(pending_vec[41]), N'(0));

      // R8 / R9 windows
      wr('h206, 'h81, "R8 set-pending");
      rd('h206, 8'h81, "R9 set-pending readback");
      rd('h286, 8'h81, "R9 clear-pending readback");
      wr('h286, 'h01, "R8 clear-pending");
      rd('h206, 8'h80, "R8 clear only bit0");
      rd('h185, 8'h02, "R9 clear-enable readback");
      wr('h185, 'h02, "R8 clear-enable");
      chk("R8 enable 41 cleared", N'(enable_vec[41]), N'(0));

      // R7 locked enables
      wr('h180, 'hFF, "R7 clear locked");
      wr('h181, 'hFF, "R7 clear locked hi");
      rd('h100, 8'hFF, "R7 locked byte0 stays");
      rd('h101, 8'hFF, "R7 locked byte1 stays");

      // R6 forced edge below 32, model bits stored
      wr('hC04, 'h00, "R6 forced edge");
      rd('hC04, 8'hAA, "R6 edge forced below 32");
      wr('hC04, 'h05, "R6 model bits");
      rd('hC04, 8'hAF, "R6 model stored");
      wr('hC10, 'hFF, "R9 out-of-range write");
      rd('hC10, 8'h00, "R9 out-of-range cfg reads zero");
      rd('h108, 8'h00, "R9 out-of-range enable reads zero");

      // R10 simultaneous events
      wr('hC08, 'h08, "R6 id33 edge");
      wr('h106, 'h04, "R8 enable 50");
      begin
         logic [N-1:0] l;
         l = irq_in; l[33] = 1'b1; l[50] = 1'b1;
         apply(l, 1'b0, 0, 0, 1'b0, 0, 1'b0, 0, "R10 two rises");
      end
      chk("R10 both pending", N'({pending_vec[50], pending_vec[33]}), N'(2'b11));
      line(50, 1'b0, "R1 fall 50");
      ack(50, "R5 ack 50");
      begin
         logic [N-1:0] l;
         l = irq_in; l[50] = 1'b1;
         apply(l, 1'b0, 0, 0, 1'b1, 50, 1'b0, 0, "R10 rise and ack");
      end
      chk("R10 set wins over ack", N'(pending_vec[50]), N'(1));

      // R3 edge and out-of-range completions
      ack(33, "R5 ack 33");
      eoi(33, "R3 eoi edge");
      chk("R3 eoi edge no re-pend", N'(pending_vec[33]), N'(0));
      eoi(1023, "R3 eoi out of range");

      repeat (2) @(negedge clk);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule